// File: doc/BRIEF.md
# SQE Heartbeat Test Pulse Generator

This block produces the signal-quality-error heartbeat that a 10 Mb/s twisted-pair PHY returns to its MAC on the collision line after each transmission. It runs on the 25 MHz reference clock of the transceiver. When the MAC ends a frame by dropping transmit enable, the block waits one microsecond (25 clocks) and then raises the collision output for one microsecond (25 clocks). The MAC uses this pulse to confirm that the collision path works.

The heartbeat is produced only while the port runs at 10 Mb/s, the SQE inhibit control bit is clear and the port is not in repeater mode. A new rise of transmit enable during the wait or the pulse abandons that heartbeat. The collision output also carries a real collision indication, which arrives from the line-sensing logic as a plain input. When the collision-test control bit is set, it also carries transmit enable, so the MAC sees a collision for as long as it transmits.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: A synchronous active-high reset returns the block to idle within the clock edge that samples it. After reset is released with transmit enable low, no heartbeat appears on `col_out`.
- R2: A heartbeat is triggered at the first clock edge that samples `tx_en` low after an edge that sampled it high, provided the block is armed. The heartbeat contribution to `col_out` stays low after that edge and after the following 24 edges (GAP_CYCLES = 25 cycles).
- R3: After the gap, the heartbeat drives `col_out` high for exactly PULSE_CYCLES = 25 consecutive cycles and then drops it.
- R4: With `mode_10m` = 0 (100 Mb/s), no heartbeat is produced.
- R5: With `sqe_inhibit` = 1, no heartbeat is produced. With `sqe_inhibit` = 0, it is produced.
- R6: With `rptr_mode` = 1, no heartbeat is produced.
- R7: If `tx_en` is sampled high while a heartbeat is waiting or pulsing, that heartbeat is abandoned, even in the last gap cycle. A later fall starts a fresh, full-length gap and pulse.
- R8: If the arming conditions (R4 to R6) become false at any clock edge during a wait or a pulse, the heartbeat is abandoned. It does not resume when they return.
- R9: `col_in` = 1 forces `col_out` high in the same cycle, whatever the heartbeat state.
- R10: With `col_test` = 1, `col_out` is also high in every cycle where `tx_en` is high. With `col_test` = 0, `tx_en` has no direct effect on `col_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | MII transmit enable from the MAC |
| mode_10m | input | 1 | 1 selects 10 Mb/s operation, 0 selects 100 Mb/s |
| sqe_inhibit | input | 1 | 1 suppresses the heartbeat |
| rptr_mode | input | 1 | 1 marks repeater operation, which suppresses the heartbeat |
| col_in | input | 1 | Real collision indication from line sensing |
| col_test | input | 1 | Collision-test control; when 1, transmit enable is echoed onto the collision output |
| col_out | output | 1 | MII collision output to the MAC |

## Verification
The hardest situations to reach from the ports are cancellations on an exact boundary. Examples are a new rise of transmit enable in the very last gap cycle, and the arming conditions dropping for a single cycle in the middle of the pulse. The stimulus reaches these by counting low cycles from the fall and placing the rise or the disarm on a chosen cycle. The bench then follows the output for the whole following window, so a pulse that survived or resumed would show up. A cancel in the middle of the pulse is followed by a fresh fall, which shows that the restart gives a full 25-cycle gap rather than the remainder of the old count.

// File: rtl/sqe_heartbeat_gen.sv
module sqe_heartbeat_gen #(
  parameter int GAP_CYCLES   = 25,
  parameter int PULSE_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic mode_10m,
  input  logic sqe_inhibit,
  input  logic rptr_mode,
  input  logic col_in,
  input  logic col_test,
  output logic col_out
);

  localparam int MAXC = (GAP_CYCLES > PULSE_CYCLES) ? GAP_CYCLES : PULSE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_PULSE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          tx_en_q;
  logic          hb;

  wire armed   = mode_10m & ~sqe_inhibit & ~rptr_mode;
  wire tx_fall = tx_en_q & ~tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q <= 1'b0;
      st      <= S_IDLE;
      cnt     <= '0;
    end else begin
      tx_en_q <= tx_en;
      if (!armed || tx_en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (tx_fall) begin
            st  <= S_GAP;
            cnt <= '0;
          end
          S_GAP: if (cnt == GAP_LAST) begin
            st  <= S_PULSE;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
          S_PULSE: if (cnt == PULSE_LAST) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
          default: begin
            st  <= S_IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  assign hb      = (st == S_PULSE);
  assign col_out = hb | col_in | (col_test & tx_en);

  // R1: reset leaves the sequencer idle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (st == S_IDLE && !hb));

  // R2: an armed fall starts the gap with the output quiet
  p_fall_starts_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && tx_fall && st == S_IDLE) |=> (st == S_GAP && cnt == '0 && !hb));

  // R2: the last gap cycle hands over to the pulse
  p_gap_to_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_GAP && cnt == GAP_LAST && armed && !tx_en) |=> hb);

  // R3: the pulse ends after its final cycle
  p_pulse_end_r3: assert property (@(posedge clk) disable iff (rst)
    (hb && cnt == PULSE_LAST && armed && !tx_en) |=> !hb);

  // R4 R5 R6 R8: losing the arming conditions removes any heartbeat
  p_disarm_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (st == S_IDLE));

  // R7: a new transmission abandons the heartbeat
  p_tx_cancel_r7: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> (st == S_IDLE));

  // R9: real collisions always reach the output
  p_col_pass_r9: assert property (@(posedge clk) disable iff (rst)
    col_in |-> col_out);

  // R10: collision test echoes transmit enable
  p_col_test_r10: assert property (@(posedge clk) disable iff (rst)
    (col_test && tx_en) |-> col_out);

endmodule

// File: tb/sim_sqe_heartbeat_gen.sv
module sim_sqe_heartbeat_gen;
  localparam int GAP   = 25;
  localparam int PULSE = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, mode_10m = 1'b1, sqe_inhibit = 1'b0, rptr_mode = 1'b0;
  logic col_in = 1'b0, col_test = 1'b0;
  logic col_out;

  always #10 clk = ~clk;

  sqe_heartbeat_gen #(.GAP_CYCLES(GAP), .PULSE_CYCLES(PULSE)) u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .mode_10m(mode_10m),
    .sqe_inhibit(sqe_inhibit), .rptr_mode(rptr_mode),
    .col_in(col_in), .col_test(col_test), .col_out(col_out)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t sb[$];

  int compared = 0;
  int mismatched = 0;
  int age = -1;
  logic prev_tx = 1'b0;
  bit done = 0;

  // Requirement-level model: age counts edges since an armed fall.
  task automatic step(input logic t, input logic m, input logic inh, input logic rp,
                      input logic ci, input logic ct, input logic rs, input string tag);
    item_t it;
    logic hbx;
    @(negedge clk);
    tx_en = t; mode_10m = m; sqe_inhibit = inh; rptr_mode = rp;
    col_in = ci; col_test = ct; rst = rs;
    if (rs) begin
      age = -1; prev_tx = 1'b0;
    end else begin
      if (!(m && !inh && !rp) || t) age = -1;
      else if (prev_tx && !t) age = 0;
      else if (age >= 0) begin
        age++;
        if (age >= GAP + PULSE) age = -1;
      end
      prev_tx = t;
    end
    hbx = (age >= GAP) && (age < GAP + PULSE);
    it.exp = hbx | ci | (ct & t);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic run(input int n, input logic t, input logic m, input logic inh,
                     input logic rp, input logic ci, input logic ct, input string tag);
    for (int k = 0; k < n; k++) step(t, m, inh, rp, ci, ct, 1'b0, tag);
  endtask

  // Frame in 10 Mb/s normal mode: high then low for a window.
  task automatic frame(input int hi, input int lo, input string tag);
    run(hi, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    run(lo, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares after each edge, before the next input change
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        compared++;
        if (col_out !== it.exp) begin
          mismatched++;
          $display("FAIL %s: col_out=%b expected=%b at %0t", it.tag, col_out, it.exp, $time);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset with tx_en high, release low: no heartbeat
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    run(60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R2 R3: basic heartbeat, gap then 25-cycle pulse
    frame(10, 70, "R2_R3");
    frame(1, 70, "R3_short_frame");
    // R4: 100 Mb/s
    run(8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    run(70, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    // R5: inhibit
    run(8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    run(70, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    // R6: repeater
    run(8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    run(70, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    // R7: rise in mid gap, rise in last gap cycle, rise mid pulse
    frame(5, 10, "R7_gap");
    frame(3, 25, "R7_lastgap");
    frame(3, 30, "R7_pulse");
    frame(2, 70, "R7_restart");
    // R8: disarm for one cycle in gap and in pulse
    frame(4, 12, "R8");
    run(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    run(60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    frame(4, 32, "R8");
    run(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    run(60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // R9: real collision in idle and during a pulse
    run(5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    frame(4, 30, "R9");
    run(10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    run(30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R10: collision test echoes tx_en, heartbeat still follows
    run(12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    run(70, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    run(6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    run(10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    // R1: reset in mid pulse clears it
    frame(4, 30, "R1_mid");
    for (int k = 0; k < 2; k++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1_mid");
    run(60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1_mid");
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule